// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs exception entry and return for a 32-bit RISC core that has branch delay slots. When the core raises an exception request, the unit works out which instruction address to save, depending on the exception class and on whether the faulting instruction sat in a delay slot. It copies the live status word into a saved-status register and produces an updated status word that records the delay-slot condition. It then redirects fetch to a handler address built from the exception code.

A return request restores the status word from the saved copy, forcing the fixed-one bit. It then redirects fetch to the saved exception PC. Illegal-instruction requests also capture the faulting address. Trap requests do not vector. They raise a one-cycle halt pulse carrying the PC, for a debugger to act on.

Requests are one-cycle pulses. Every result appears on the registered outputs one clock edge after the request.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register clears to zero: saved PC, saved status, status, effective address, redirect and halt strobes and addresses, error flag and pending delay-slot flag.
- R2: Codes 0xC (system call) and 0xD (floating point) save `req_pc + 4`, or `req_pc` itself when `req_dslot` is 1.
- R3: Codes 0x2 (bus error), 0x6 (alignment), 0x7 (illegal instruction) and 0xB (range) save `req_pc`, or `req_pc - 4` when `req_dslot` is 1.
- R4: Code 0x1 (reset) performs entry but leaves the saved PC unchanged.
- R5: Any code outside {0x1, 0x2, 0x6, 0x7, 0xB, 0xC, 0xD, 0xE} performs entry, leaves the saved PC unchanged and pulses `bad_code` for exactly the cycle that carries its redirect.
- R6: On entry, `esr_q` takes the whole of `sr_in`. `sr_q` takes `sr_in` with bit 13 (delay-slot-exception) replaced by `req_dslot`.
- R7: One edge after an entry request, `redir_valid` is 1 for one cycle. `redir_pc` is then `code << 8`, plus 0xF000_0000 when bit 14 of `sr_in` (high vector base) is 1.
- R8: Code 0x7 loads `eear_q` with `req_pc`. Every other request leaves `eear_q` unchanged.
- R9: Code 0xE (trap) raises `halt_valid` for one cycle, with `halt_pc` equal to `req_pc`. It does not redirect, and it leaves the saved PC, saved status, status and effective address unchanged.
- R10: A return request sets `sr_q` to `esr_q` with bit 15 (fixed-one) forced to 1. It pulses `redir_valid`, with `redir_pc` equal to the saved PC held before that edge.
- R11: `dslot_pend_q` follows `dslot_next` one edge later, except that any entry or return forces it to 0.
- R12: When an entry request and a return request arrive in the same cycle, only the entry takes effect. A trap in the same cycle as a return likewise suppresses the return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request pulse |
| req_code | input | 4 | Exception code |
| req_pc | input | 32 | Faulting instruction address |
| req_dslot | input | 1 | Faulting instruction sits in a delay slot |
| sr_in | input | 32 | Live status word at request time |
| rfe_valid | input | 1 | Return-from-exception request pulse |
| dslot_next | input | 1 | Core marks the next instruction as a delay slot |
| epc_q | output | 32 | Saved exception PC |
| esr_q | output | 32 | Saved status word |
| sr_q | output | 32 | Updated status word |
| eear_q | output | 32 | Captured effective address |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_pc | output | 32 | Redirect target |
| halt_valid | output | 1 | Debug halt strobe |
| halt_pc | output | 32 | PC reported with the halt |
| bad_code | output | 1 | Unknown exception code seen |
| dslot_pend_q | output | 1 | Pending delay-slot state |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, a shift of 8, a high base of 0xF000_0000, and status bits 13, 14 and 15. These defaults make the handler addresses and the status-bit edits reach exactly the values the requirements name. A fixed-seed random mix draws from every defined code and from the unknown ones, with random delay-slot flags, status words and PCs. This covers both the PC-rewind and PC-advance classes. Directed cases exercise the PC wrapping at zero, entry colliding with a return, trap colliding with a return, and a return right after an entry.

// File: rtl/exc_pkg.sv
// Shared exception codes and widths for the exception entry unit.
// Assumes a 4-bit exception code field.
package exc_pkg;
    localparam int EXC_W = 4;

    typedef enum logic [EXC_W-1:0] {
        EXC_RESET   = 4'h1,
        EXC_BUSERR  = 4'h2,
        EXC_ALIGN   = 4'h6,
        EXC_ILLEGAL = 4'h7,
        EXC_RANGE   = 4'hB,
        EXC_SYSCALL = 4'hC,
        EXC_FPE     = 4'hD,
        EXC_TRAP    = 4'hE
    } exc_code_e;

    typedef enum logic [1:0] {
        PCK_ADVANCE = 2'd0,
        PCK_REWIND  = 2'd1,
        PCK_KEEP    = 2'd2,
        PCK_UNKNOWN = 2'd3
    } pc_kind_e;
endpackage

// File: rtl/exc_pc_select.sv
// Computes the next saved exception PC from the exception class.
// Assumes: combinational only; the caller decides whether to load it.
module exc_pc_select
    import exc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [EXC_W-1:0] code,
    input  logic [XLEN-1:0]  fault_pc,
    input  logic             in_dslot,
    input  logic [XLEN-1:0]  epc_cur,
    output logic [XLEN-1:0]  epc_nxt,
    output logic             code_known
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    pc_kind_e kind;

    // Classify the code into the PC treatment it needs.
    always_comb begin
        case (code)
            EXC_SYSCALL, EXC_FPE:                          kind = PCK_ADVANCE;
            EXC_BUSERR, EXC_ALIGN, EXC_ILLEGAL, EXC_RANGE: kind = PCK_REWIND;
            EXC_RESET, EXC_TRAP:                           kind = PCK_KEEP;
            default:                                       kind = PCK_UNKNOWN;
        endcase
    end

    // Apply the class rule and the delay-slot rewind.
    always_comb begin
        code_known = (kind != PCK_UNKNOWN);
        case (kind)
            PCK_ADVANCE: epc_nxt = in_dslot ? fault_pc : fault_pc + STEP;
            PCK_REWIND:  epc_nxt = in_dslot ? fault_pc - STEP : fault_pc;
            default:     epc_nxt = epc_cur;
        endcase
    end
endmodule

// File: rtl/exc_vector_gen.sv
// Builds the handler address from the code and the high-base status bit.
// Assumes the shifted code fits in the word.
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              VEC_SHIFT = 8,
    parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000
) (
    input  logic [EXC_W-1:0] code,
    input  logic             hi_sel,
    output logic [XLEN-1:0]  vec_addr
);
    localparam int USED = VEC_SHIFT + EXC_W;

    logic [XLEN-1:0] offset;

    // Place the code at its shift; pad the upper bits when the word is wider.
    generate
        if (USED < XLEN) begin : g_pad
            assign offset = {{(XLEN-USED){1'b0}}, code, {VEC_SHIFT{1'b0}}};
        end else begin : g_trunc
            assign offset = XLEN'({code, {VEC_SHIFT{1'b0}}});
        end
    endgenerate

    // Add the base picked by the status bit.
    always_comb vec_addr = offset + (hi_sel ? HI_BASE : '0);
endmodule

// File: rtl/exc_status_upd.sv
// Computes the next status word for entry and return.
// Assumes entry and return are already made exclusive by the caller.
module exc_status_upd #(
    parameter int XLEN    = 32,
    parameter int DSX_BIT = 13,
    parameter int FO_BIT  = 15
) (
    input  logic            do_entry,
    input  logic            do_return,
    input  logic            in_dslot,
    input  logic [XLEN-1:0] sr_live,
    input  logic [XLEN-1:0] sr_saved,
    input  logic [XLEN-1:0] sr_cur,
    output logic [XLEN-1:0] sr_nxt
);
    // Select the source word and patch the single bit each path owns.
    always_comb begin
        sr_nxt = sr_cur;
        if (do_entry) begin
            sr_nxt          = sr_live;
            sr_nxt[DSX_BIT] = in_dslot;
        end else if (do_return) begin
            sr_nxt          = sr_saved;
            sr_nxt[FO_BIT]  = 1'b1;
        end
    end
endmodule

// File: rtl/exc_entry_unit.sv
// Exception entry/return unit: registers the saved PC and status, the
// updated status, the effective address, and redirect and halt strobes.
// Assumes single-cycle request pulses; entry (including trap) beats return.
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              INSN_BYTES = 4,
    parameter int              VEC_SHIFT  = 8,
    parameter logic [XLEN-1:0] HI_BASE    = 32'hF000_0000,
    parameter int              DSX_BIT    = 13,
    parameter int              EPH_BIT    = 14,
    parameter int              FO_BIT     = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [EXC_W-1:0] req_code,
    input  logic [XLEN-1:0]  req_pc,
    input  logic             req_dslot,
    input  logic [XLEN-1:0]  sr_in,
    input  logic             rfe_valid,
    input  logic             dslot_next,
    output logic [XLEN-1:0]  epc_q,
    output logic [XLEN-1:0]  esr_q,
    output logic [XLEN-1:0]  sr_q,
    output logic [XLEN-1:0]  eear_q,
    output logic             redir_valid,
    output logic [XLEN-1:0]  redir_pc,
    output logic             halt_valid,
    output logic [XLEN-1:0]  halt_pc,
    output logic             bad_code,
    output logic             dslot_pend_q
);
    logic            is_trap, do_entry, do_trap, do_return;
    logic            code_known;
    logic [XLEN-1:0] epc_nxt, vec_addr, sr_nxt;

    // Arbitrate: any request (entry or trap) suppresses a return.
    always_comb begin
        is_trap   = (req_code == EXC_TRAP);
        do_entry  = req_valid && !is_trap;
        do_trap   = req_valid && is_trap;
        do_return = rfe_valid && !req_valid;
    end

    exc_pc_select #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_pc (
        .code(req_code), .fault_pc(req_pc), .in_dslot(req_dslot),
        .epc_cur(epc_q), .epc_nxt(epc_nxt), .code_known(code_known)
    );

    exc_vector_gen #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .HI_BASE(HI_BASE)) u_vec (
        .code(req_code), .hi_sel(sr_in[EPH_BIT]), .vec_addr(vec_addr)
    );

    exc_status_upd #(.XLEN(XLEN), .DSX_BIT(DSX_BIT), .FO_BIT(FO_BIT)) u_sr (
        .do_entry(do_entry), .do_return(do_return), .in_dslot(req_dslot),
        .sr_live(sr_in), .sr_saved(esr_q), .sr_cur(sr_q), .sr_nxt(sr_nxt)
    );

    // Architectural state: saved PC, saved status, status, effective address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q  <= '0;
            esr_q  <= '0;
            sr_q   <= '0;
            eear_q <= '0;
        end else begin
            sr_q <= sr_nxt;
            if (do_entry) begin
                epc_q <= epc_nxt;
                esr_q <= sr_in;
                if (req_code == EXC_ILLEGAL) eear_q <= req_pc;
            end
        end
    end

    // One-cycle strobes for redirect, halt and the bad-code flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            halt_valid  <= 1'b0;
            halt_pc     <= '0;
            bad_code    <= 1'b0;
        end else begin
            redir_valid <= do_entry || do_return;
            redir_pc    <= do_entry ? vec_addr : (do_return ? epc_q : '0);
            halt_valid  <= do_trap;
            halt_pc     <= do_trap ? req_pc : '0;
            bad_code    <= do_entry && !code_known;
        end
    end

    // Pending delay-slot state, flushed by any entry or return.
    always_ff @(posedge clk) begin
        if (!rst_n) dslot_pend_q <= 1'b0;
        else        dslot_pend_q <= (do_entry || do_return) ? 1'b0 : dslot_next;
    end
endmodule

// File: rtl/exc_entry_chk.sv
// Assertion checker for exc_entry_unit, attached through bind.
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int FO_BIT = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [EXC_W-1:0] req_code,
    input logic             rfe_valid,
    input logic [XLEN-1:0]  epc_q,
    input logic [XLEN-1:0]  esr_q,
    input logic [XLEN-1:0]  sr_q,
    input logic [XLEN-1:0]  eear_q,
    input logic             redir_valid,
    input logic [XLEN-1:0]  redir_pc,
    input logic             halt_valid,
    input logic             bad_code,
    input logic             dslot_pend_q
);
    // R9
    halt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({redir_valid, halt_valid}));

    // R9
    trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_valid |-> ($stable(epc_q) && $stable(esr_q) && $stable(sr_q) && $stable(eear_q)));

    // R5
    bad_code_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_code |-> redir_valid);

    // R10
    rfe_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rfe_valid) && !$past(req_valid)) |-> (redir_valid && redir_pc == $past(epc_q)));

    // R10
    rfe_fo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rfe_valid) && !$past(req_valid)) |-> sr_q[FO_BIT]);

    // R11
    dslot_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !dslot_pend_q);

    // R7
    redir_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && $past(rst_n)) |-> ($past(rfe_valid) || ($past(req_valid) && $past(req_code) != EXC_TRAP)));
endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN), .FO_BIT(FO_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .rfe_valid(rfe_valid), .epc_q(epc_q), .esr_q(esr_q), .sr_q(sr_q),
    .eear_q(eear_q), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .halt_valid(halt_valid), .bad_code(bad_code), .dslot_pend_q(dslot_pend_q)
);

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_dslot = 1'b0, rfe_valid = 1'b0, dslot_next = 1'b0;
    logic [3:0]  req_code = '0;
    logic [31:0] req_pc = '0, sr_in = '0;
    logic [31:0] epc_q, esr_q, sr_q, eear_q, redir_pc, halt_pc;
    logic        redir_valid, halt_valid, bad_code, dslot_pend_q;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [31:0] m_epc = '0, m_esr = '0, m_sr = '0, m_eear = '0;

    always #2.5 clk = ~clk;

    exc_entry_unit dut (.*);

    function automatic bit known_code(input logic [3:0] c);
        return c inside {4'h1, 4'h2, 4'h6, 4'h7, 4'hB, 4'hC, 4'hD, 4'hE};
    endfunction

    function automatic logic [31:0] exp_epc(input logic [3:0] c, input logic [31:0] pc,
                                            input logic ds, input logic [31:0] cur);
        if (c == 4'hC || c == 4'hD) return ds ? pc : pc + 32'd4;   // R2
        if (c inside {4'h2, 4'h6, 4'h7, 4'hB}) return ds ? pc - 32'd4 : pc; // R3
        return cur;                                                 // R4, R5
    endfunction

    function automatic logic [31:0] exp_vec(input logic [3:0] c, input logic eph);
        return {20'd0, c, 8'd0} + (eph ? 32'hF000_0000 : 32'd0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request cycle at the falling edge, check one edge later.
    task automatic step(input logic v, input logic [3:0] c, input logic [31:0] pc,
                        input logic ds, input logic [31:0] sr, input logic rfe, input logic dn);
        logic entry, trap, ret;
        logic [31:0] e_epc, e_esr, e_sr, e_eear;
        req_valid = v; req_code = c; req_pc = pc; req_dslot = ds;
        sr_in = sr; rfe_valid = rfe; dslot_next = dn;
        entry = v && c != 4'hE;
        trap  = v && c == 4'hE;
        ret   = rfe && !v;                                          // R12
        e_epc = entry ? exp_epc(c, pc, ds, m_epc) : m_epc;
        e_esr = entry ? sr : m_esr;                                 // R6
        e_sr  = m_sr;
        if (entry) begin e_sr = sr; e_sr[13] = ds; end              // R6
        else if (ret) begin e_sr = m_esr; e_sr[15] = 1'b1; end      // R10
        e_eear = (entry && c == 4'h7) ? pc : m_eear;                // R8
        @(negedge clk);
        chk("R2/R3/R4 epc", epc_q, e_epc);
        chk("R6 esr", esr_q, e_esr);
        chk("R6/R10 sr", sr_q, e_sr);
        chk("R8 eear", eear_q, e_eear);
        chk("R7/R10/R12 redir_valid", {31'd0, redir_valid}, {31'd0, entry || ret});
        if (entry) chk("R7 redir_pc", redir_pc, exp_vec(c, sr[14]));
        if (ret)   chk("R10 redir_pc", redir_pc, m_epc);
        chk("R9 halt_valid", {31'd0, halt_valid}, {31'd0, trap});
        if (trap) chk("R9 halt_pc", halt_pc, pc);
        chk("R5 bad_code", {31'd0, bad_code}, {31'd0, entry && !known_code(c)});
        chk("R11 dslot_pend", {31'd0, dslot_pend_q}, {31'd0, (entry || ret) ? 1'b0 : dn});
        m_epc = e_epc; m_esr = e_esr; m_sr = e_sr; m_eear = e_eear;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 epc", epc_q, 0);   chk("R1 esr", esr_q, 0);
        chk("R1 sr", sr_q, 0);     chk("R1 eear", eear_q, 0);
        chk("R1 strobes", {28'd0, redir_valid, halt_valid, bad_code, dslot_pend_q}, 0);
        rst_n = 1'b1;
        // Directed corners
        step(1, 4'hC, 32'h0000_1000, 0, 32'h0000_4000, 0, 1); // R2 advance, high base
        step(1, 4'hD, 32'h0000_2000, 1, 32'h0000_0000, 0, 0); // R2 delay slot
        step(1, 4'h2, 32'h0000_0000, 1, 32'h0000_0000, 0, 0); // R3 wrap below zero
        step(1, 4'h7, 32'h0000_3004, 0, 32'hFFFF_FFFF, 0, 0); // R8 illegal, R6 DSX cleared
        step(0, 4'h0, 32'h0, 0, 32'h0, 1, 1);                 // R10 return
        step(1, 4'h1, 32'h0000_5000, 1, 32'h0000_0001, 0, 0); // R4 reset keeps epc
        step(1, 4'h9, 32'h0000_6000, 0, 32'h0000_0002, 0, 1); // R5 unknown code
        step(1, 4'hE, 32'h0000_7000, 1, 32'h1234_5678, 0, 1); // R9 trap
        step(1, 4'h6, 32'h0000_8000, 0, 32'h0000_4000, 1, 1); // R12 entry beats return
        step(1, 4'hE, 32'h0000_9000, 0, 32'h0, 1, 0);         // R12 trap beats return
        step(0, 4'h0, 32'h0, 0, 32'h0, 0, 1);                 // R11 follow
        step(0, 4'h0, 32'h0, 0, 32'h0, 1, 0);                 // R10 again
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] c;
            c = ($urandom % 4 == 0) ? 4'($urandom) : 4'(($urandom % 2) ? 4'hC : 4'h2);
            if ($urandom % 3 == 0) c = 4'({4'h1, 4'h6, 4'h7, 4'hB, 4'hD, 4'hE} >> (4 * ($urandom % 6)));
            step(1'($urandom % 3 != 0), c, $urandom & 32'hFFFF_FFFC, 1'($urandom),
                 $urandom, 1'($urandom % 4 == 0), 1'($urandom));
        end
        // R1: reset again clears state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 epc after reset", epc_q, 0);
        chk("R1 sr after reset", sr_q, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule